// File: doc/BRIEF.md
# Type 1 Configuration Transaction Router

This block sits in the address-phase path of a PCI/PCI-X style bridge and decides what the bridge does with a Type 1 configuration transaction. On a one-cycle strobe it samples the address/data word, the command nibble, the direction of travel (toward the child buses or toward the host) and the bus mode. It then compares the target bus number with the bridge's primary, secondary and subordinate bus number settings.

The outcome is a registered one-hot decision with four possible values: not claimed, forward unchanged, turn into a special cycle, or turn into a Type 0 access on the child bus. A companion pair of flags tells the completion logic whether a crossing transaction is handled as a delayed transaction (conventional mode) or as a split transaction (PCI-X mode). The decision and the flags stay fixed until the next strobe, so the bus-side sequencers can read them at any later point.

Top module: `cfg1_router`

## Requirements
- R1: A transaction is claimed only if the command is 4'b1010 (config read) or 4'b1011 (config write) and address bits [1:0] are 2'b01. Any other command or low-bit pattern yields "not claimed".
- R2: Downstream, a claimed transaction whose bus number (address bits [23:16]) is strictly above the secondary bus number and at or below the subordinate bus number is forwarded unchanged.
- R3: Downstream, when the bus number equals the secondary bus number, a config write that carries the special pattern becomes a special cycle. Every other claimed transaction to that bus becomes a Type 0 access. The special pattern is device bits [15:11] = 5'b11111, function bits [10:8] = 3'b111 and register bits [7:2] = 6'b000000.
- R4: Downstream, a bus number below the secondary number or above the subordinate number is not claimed.
- R5: Upstream, every config read is not claimed, whatever its bus number.
- R6: Upstream, a config write with the special pattern whose bus number equals the primary bus number becomes a special cycle.
- R7: Upstream, a config write with the special pattern whose bus number is not the primary number and lies outside the secondary-to-subordinate span is forwarded unchanged. Every other upstream write is not claimed.
- R8: When the decision is forward or Type 0, `cpl_split` shows the captured PCI-X mode and `cpl_delayed` shows its inverse. For any other decision both flags are 0.
- R9: `route` is one-hot, with bit0 = not claimed, bit1 = forward, bit2 = special cycle and bit3 = Type 0. It changes on the clock edge that samples the strobe and holds its value while the strobe is low.
- R10: A synchronous reset sets `route` to "not claimed" and clears both completion flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_phase | input | 1 | One-cycle address-phase strobe |
| ad | input | 32 | Address/data word of the address phase |
| cbe | input | 4 | Command nibble |
| upstream | input | 1 | 1 = travelling toward the host, 0 = toward child buses |
| pcix_mode | input | 1 | 1 = PCI-X mode, 0 = conventional mode |
| pri_bus | input | 8 | Primary bus number setting |
| sec_bus | input | 8 | Secondary bus number setting |
| sub_bus | input | 8 | Subordinate bus number setting |
| route | output | 4 | One-hot routing decision |
| cpl_split | output | 1 | Crossing transaction uses split completion |
| cpl_delayed | output | 1 | Crossing transaction uses delayed completion |

## Verification
The bench uses the default parameters: a 32-bit address word with an 8-bit bus number at bit 16. With only 256 bus numbers, random picks that are biased toward the secondary number, its neighbours, the subordinate number plus one and the primary number land on each edge of the exclusive/inclusive window many times. Directed cases cover a secondary number equal to the subordinate number (an empty child range) and the extremes 0 and 255.

// File: rtl/cfg1_route_pkg.sv
package cfg1_route_pkg;

  typedef enum logic [3:0] {
    RT_NONE  = 4'b0001,
    RT_FWD   = 4'b0010,
    RT_SPCL  = 4'b0100,
    RT_TYPE0 = 4'b1000
  } route_e;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
  localparam logic [1:0] TYPE1_TAG  = 2'b01;

  // device/function/register field that asks for a special cycle, bits [15:2]
  localparam logic [13:0] SPCL_FIELD = {5'b11111, 3'b111, 6'b000000};

  function automatic logic f_claim_cmd(input logic [3:0] cmd, input logic [1:0] tag);
    return ((cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR)) && (tag == TYPE1_TAG);
  endfunction

  function automatic logic f_spcl_field(input logic [13:0] dfr);
    return dfr == SPCL_FIELD;
  endfunction

endpackage

// File: rtl/cfg1_addr_decode.sv
module cfg1_addr_decode
  import cfg1_route_pkg::*;
#(
  parameter int AW      = 32,
  parameter int BUS_W   = 8,
  parameter int BUS_LSB = 16
) (
  input  logic [AW-1:0]    ad,
  input  logic [3:0]       cbe,
  output logic             claimed,
  output logic             is_wr,
  output logic             spcl_pat,
  output logic [BUS_W-1:0] bus_num
);
  localparam int BUS_MSB = BUS_LSB + BUS_W - 1;

  logic unused_hi;

  assign claimed  = f_claim_cmd(cbe, ad[1:0]);
  assign is_wr    = (cbe == CMD_CFG_WR);
  assign spcl_pat = f_spcl_field(ad[15:2]);
  assign bus_num  = ad[BUS_MSB:BUS_LSB];

  generate
    if (BUS_MSB < AW - 1) begin : g_hi
      assign unused_hi = ^ad[AW-1:BUS_MSB+1];
    end else begin : g_nohi
      assign unused_hi = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cfg1_bus_window.sv
module cfg1_bus_window #(
  parameter int BUS_W = 8
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] pri,
  input  logic [BUS_W-1:0] sec,
  input  logic [BUS_W-1:0] sub,
  output logic             eq_pri,
  output logic             eq_sec,
  output logic             in_child,
  output logic             in_span
);
  logic above_sec, not_below_sec, within_sub;

  assign eq_pri        = (bus == pri);
  assign eq_sec        = (bus == sec);
  assign above_sec     = (bus > sec);
  assign not_below_sec = above_sec || eq_sec;
  assign within_sub    = (bus <= sub);
  assign in_child      = above_sec && within_sub;
  assign in_span       = not_below_sec && within_sub;

  always_comb begin
    AST_CHILD_IN_SPAN: assert (!in_child || in_span); // R2
  end
endmodule

// File: rtl/cfg1_route_sel.sv
module cfg1_route_sel
  import cfg1_route_pkg::*;
(
  input  logic   claimed,
  input  logic   is_wr,
  input  logic   spcl_pat,
  input  logic   upstream,
  input  logic   eq_pri,
  input  logic   eq_sec,
  input  logic   in_child,
  input  logic   in_span,
  output route_e route_d
);
  logic spcl_wr;
  assign spcl_wr = is_wr && spcl_pat;

  always_comb begin
    route_d = RT_NONE;
    if (claimed) begin
      if (upstream) begin
        if (spcl_wr && eq_pri)        route_d = RT_SPCL;
        else if (spcl_wr && !in_span) route_d = RT_FWD;
      end else begin
        if (eq_sec)                   route_d = spcl_wr ? RT_SPCL : RT_TYPE0;
        else if (in_child)            route_d = RT_FWD;
      end
    end
  end

  always_comb begin
    AST_NEXT_ONEHOT: assert ($onehot(route_d)); // R9
  end
endmodule

// File: rtl/cfg1_router.sv
module cfg1_router
  import cfg1_route_pkg::*;
#(
  parameter int AW      = 32,
  parameter int BUS_W   = 8,
  parameter int BUS_LSB = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_phase,
  input  logic [AW-1:0]    ad,
  input  logic [3:0]       cbe,
  input  logic             upstream,
  input  logic             pcix_mode,
  input  logic [BUS_W-1:0] pri_bus,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output logic [3:0]       route,
  output logic             cpl_split,
  output logic             cpl_delayed
);
  logic             claimed, is_wr, spcl_pat;
  logic [BUS_W-1:0] bus_num;
  logic             eq_pri, eq_sec, in_child, in_span;
  route_e           route_d, route_q;
  logic             pcix_q;
  logic             crossing;

  cfg1_addr_decode #(.AW(AW), .BUS_W(BUS_W), .BUS_LSB(BUS_LSB)) u_dec (
    .ad(ad), .cbe(cbe), .claimed(claimed), .is_wr(is_wr),
    .spcl_pat(spcl_pat), .bus_num(bus_num)
  );

  cfg1_bus_window #(.BUS_W(BUS_W)) u_win (
    .bus(bus_num), .pri(pri_bus), .sec(sec_bus), .sub(sub_bus),
    .eq_pri(eq_pri), .eq_sec(eq_sec), .in_child(in_child), .in_span(in_span)
  );

  cfg1_route_sel u_sel (
    .claimed(claimed), .is_wr(is_wr), .spcl_pat(spcl_pat), .upstream(upstream),
    .eq_pri(eq_pri), .eq_sec(eq_sec), .in_child(in_child), .in_span(in_span),
    .route_d(route_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= RT_NONE;
      pcix_q  <= 1'b0;
    end else if (addr_phase) begin
      route_q <= route_d;
      pcix_q  <= pcix_mode;
    end
  end

  assign crossing    = (route_q == RT_FWD) || (route_q == RT_TYPE0);
  assign route       = route_q;
  assign cpl_split   = crossing && pcix_q;
  assign cpl_delayed = crossing && !pcix_q;

  AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(route)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !addr_phase |=> $stable(route)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (route == RT_NONE) && !cpl_split && !cpl_delayed); // R10
  AST_BAD_TAG: assert property (@(posedge clk) disable iff (rst)
    (addr_phase && ad[1:0] != TYPE1_TAG) |=> route == RT_NONE); // R1
  AST_UP_READ: assert property (@(posedge clk) disable iff (rst)
    (addr_phase && upstream && cbe == CMD_CFG_RD) |=> route == RT_NONE); // R5
  AST_CPL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cpl_split && cpl_delayed)); // R8
  AST_CPL_ONLY_XFER: assert property (@(posedge clk) disable iff (rst)
    (cpl_split || cpl_delayed) |-> (route == RT_FWD || route == RT_TYPE0)); // R8
endmodule

// File: tb/test_cfg1_router.sv
module test_cfg1_router;
  logic        clk = 1'b0;
  logic        rst, addr_phase, upstream, pcix_mode;
  logic [31:0] ad;
  logic [3:0]  cbe, route;
  logic [7:0]  pri_bus, sec_bus, sub_bus;
  logic        cpl_split, cpl_delayed;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  cfg1_router i_cfg1_router (
    .clk(clk), .rst(rst), .addr_phase(addr_phase), .ad(ad), .cbe(cbe),
    .upstream(upstream), .pcix_mode(pcix_mode), .pri_bus(pri_bus),
    .sec_bus(sec_bus), .sub_bus(sub_bus), .route(route),
    .cpl_split(cpl_split), .cpl_delayed(cpl_delayed)
  );

  function automatic logic [3:0] model(input logic [31:0] a, input logic [3:0] c,
                                       input logic up, input logic [7:0] p,
                                       input logic [7:0] s, input logic [7:0] u);
    logic [7:0] b;
    logic rd, wr, pat;
    b   = a[23:16];
    rd  = (c == 4'hA);
    wr  = (c == 4'hB);
    pat = (a[15:11] == 5'h1f) && (a[10:8] == 3'h7) && (a[7:2] == 6'd0);
    if (!(rd || wr) || a[1:0] != 2'b01) return 4'b0001;
    if (up) begin
      if (rd || !pat)        return 4'b0001;
      if (b == p)            return 4'b0100;
      if (b < s || b > u)    return 4'b0010;
      return 4'b0001;
    end
    if (b == s)              return (wr && pat) ? 4'b0100 : 4'b1000;
    if (b > s && b <= u)     return 4'b0010;
    return 4'b0001;
  endfunction

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s route/split/delayed got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [5:0] pack(input logic [3:0] r, input logic pcx);
    logic x;
    x = (r == 4'b0010) || (r == 4'b1000);
    return {r, x && pcx, x && !pcx};
  endfunction

  function automatic string tag_of(input logic [31:0] a, input logic [3:0] c,
                                   input logic up, input logic [7:0] s, input logic [7:0] u);
    logic [7:0] b;
    b = a[23:16];
    if (!((c == 4'hA) || (c == 4'hB)) || a[1:0] != 2'b01) return "R1";
    if (up) return (c == 4'hA) ? "R5" : "R6/R7";
    if (b == s) return "R3";
    if (b > s && b <= u) return "R2";
    return "R4";
  endfunction

  // apply one strobe, check the edge result (R8, R9) and then check hold (R9)
  task automatic txn(input logic [31:0] a, input logic [3:0] c, input logic up,
                     input logic pcx, input logic [7:0] p, input logic [7:0] s,
                     input logic [7:0] u);
    logic [5:0] exp;
    @(negedge clk);
    ad = a; cbe = c; upstream = up; pcix_mode = pcx;
    pri_bus = p; sec_bus = s; sub_bus = u; addr_phase = 1'b1;
    exp = pack(model(a, c, up, p, s, u), pcx);
    @(negedge clk);
    addr_phase = 1'b0;
    check({tag_of(a, c, up, s, u), " R8"}, {route, cpl_split, cpl_delayed}, exp);
    ad = $urandom; cbe = 4'(~c); upstream = ~up; pcix_mode = ~pcx;
    @(negedge clk);
    check("R9 hold", {route, cpl_split, cpl_delayed}, exp);
  endtask

  function automatic logic [31:0] mk(input logic [7:0] b, input bit pat, input logic [1:0] t);
    logic [31:0] a;
    a = $urandom;
    a[23:16] = b;
    if (pat) a[15:2] = {5'h1f, 3'h7, 6'h00};
    a[1:0] = t;
    return a;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; addr_phase = 1'b0; ad = '0; cbe = '0; upstream = 1'b0;
    pcix_mode = 1'b0; pri_bus = 8'd0; sec_bus = 8'd0; sub_bus = 8'd0;
    repeat (3) @(negedge clk);
    check("R10 reset", {route, cpl_split, cpl_delayed}, 6'b000100);
    rst = 1'b0;

    // directed corners
    txn(mk(8'd5, 0, 2'b01), 4'hA, 0, 1, 8'd1, 8'd4, 8'd9);   // R2 sec+1, split
    txn(mk(8'd9, 0, 2'b01), 4'hB, 0, 0, 8'd1, 8'd4, 8'd9);   // R2 sub inclusive, delayed
    txn(mk(8'd10, 0, 2'b01), 4'hA, 0, 0, 8'd1, 8'd4, 8'd9);  // R4 sub+1
    txn(mk(8'd3, 0, 2'b01), 4'hA, 0, 0, 8'd1, 8'd4, 8'd9);   // R4 below sec
    txn(mk(8'd4, 1, 2'b01), 4'hB, 0, 1, 8'd1, 8'd4, 8'd9);   // R3 special
    txn(mk(8'd4, 1, 2'b01), 4'hA, 0, 1, 8'd1, 8'd4, 8'd9);   // R3 read -> type0
    txn(mk(8'd4, 0, 2'b01), 4'hB, 0, 0, 8'd1, 8'd4, 8'd9);   // R3 write no pattern
    txn(mk(8'd5, 0, 2'b00), 4'hA, 0, 0, 8'd1, 8'd4, 8'd9);   // R1 tag 00
    txn(mk(8'd5, 0, 2'b01), 4'h6, 0, 0, 8'd1, 8'd4, 8'd9);   // R1 mem read cmd
    txn(mk(8'd1, 1, 2'b01), 4'hA, 1, 0, 8'd1, 8'd4, 8'd9);   // R5 upstream read
    txn(mk(8'd1, 1, 2'b01), 4'hB, 1, 0, 8'd1, 8'd4, 8'd9);   // R6
    txn(mk(8'd0, 1, 2'b01), 4'hB, 1, 1, 8'd1, 8'd4, 8'd9);   // R7 outside span
    txn(mk(8'd6, 1, 2'b01), 4'hB, 1, 1, 8'd1, 8'd4, 8'd9);   // R7 inside span
    txn(mk(8'd0, 0, 2'b01), 4'hB, 1, 1, 8'd1, 8'd4, 8'd9);   // R7 no pattern
    txn(mk(8'd7, 0, 2'b01), 4'hA, 0, 1, 8'd0, 8'd7, 8'd7);   // R3 sec==sub
    txn(mk(8'd8, 0, 2'b01), 4'hA, 0, 1, 8'd0, 8'd7, 8'd7);   // R4 sec==sub
    txn(mk(8'd255, 0, 2'b01), 4'hB, 0, 1, 8'd0, 8'd0, 8'd255); // R2 top edge
    txn(mk(8'd0, 0, 2'b01), 4'hB, 0, 1, 8'd0, 8'd0, 8'd255);   // R3 bus 0

    // R10 reset while a forward decision is held
    txn(mk(8'd5, 0, 2'b01), 4'hA, 0, 1, 8'd1, 8'd4, 8'd9);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 mid-run reset", {route, cpl_split, cpl_delayed}, 6'b000100);

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] s, u, p, b;
      logic [3:0] c;
      logic [1:0] t;
      int k;
      s = $urandom; u = $urandom; p = $urandom;
      if (u < s) begin b = u; u = s; s = b; end
      k = $urandom_range(0, 6);
      case (k)
        0: b = s;
        1: b = s + 8'd1;
        2: b = u;
        3: b = u + 8'd1;
        4: b = p;
        5: b = s - 8'd1;
        default: b = $urandom;
      endcase
      k = $urandom_range(0, 9);
      c = (k < 4) ? 4'hA : (k < 8) ? 4'hB : 4'($urandom);
      t = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b01;
      txn(mk(b, $urandom_range(0, 1) == 1, t), c, 1'($urandom), 1'($urandom), p, s, u);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule